// File: doc/BRIEF.md
# Sector Write-Mode Sequencer

This block sits between a host command decoder and a flash back-end. For each accepted sector command it decides which flash steps to issue (erase, program, margin verify, read), strobes them one at a time and waits for the back-end's done pulse after each. A small table holds, for every sector, a pre-erased flag and a saturating program-cycle counter. The table chooses between a full write sequence and the shortened ones that a pre-erased sector allows.

A write that may skip its erase drops the final margin verify while the sector's cycle count is at or below a threshold, and keeps the verify once the count exceeds it. A read of a pre-erased sector returns all-zero data and never reports an error, because the stored check code of an erased sector is not valid. A wear-level command completes with no flash activity. A command that arrives while the block is busy is rejected.

Top module: `wmode_seq`

## Requirements
- R1: A normal write (cmd_op=1) issues erase, program and verify strobes in that order and nothing else, whether or not the sector is pre-erased; all step strobes are one-hot and carry the command's sector on fl_sect.
- R2: An erase command (cmd_op=3) issues only an erase strobe and marks the sector pre-erased; every completed erase step adds one to that sector's cycle count, which saturates at 2**CNT_W-1.
- R3: A write-without-erase (cmd_op=2) to a pre-erased sector whose count is at or below VERIFY_LIMIT issues a program strobe only.
- R4: A write-without-erase to a pre-erased sector whose count is above VERIFY_LIMIT issues program then verify, with no erase.
- R5: A write-without-erase to a sector that is not pre-erased issues erase, program and verify.
- R6: A completed program step clears the sector's pre-erased flag.
- R7: A read (cmd_op=0) of a pre-erased sector issues one read strobe and, with rd_valid, returns rd_data of all zeros and rd_err low whatever fl_rdata and fl_ecc_err carry.
- R8: A read of a sector that is not pre-erased returns fl_rdata and fl_ecc_err as sampled with the read step's fl_done.
- R9: A wear-level command (cmd_op=4) and the unused codes 5 to 7 complete with no strobe and leave the flag and count of the sector unchanged.
- R10: cmd_valid while busy is high is not accepted: cmd_rej is high in the next cycle and the command has no effect on strobes or on the table.
- R11: busy rises in the cycle after acceptance and holds through the cmd_done cycle; the first strobe is high in the cycle after acceptance, each later strobe or cmd_done is high in the cycle after the edge that samples fl_done, a command with no steps raises cmd_done in the cycle after acceptance, and every strobe and cmd_done lasts one cycle.
- R12: After reset busy, cmd_done, cmd_rej and all strobes are low, every count is zero and no sector is pre-erased.
- R13: qry_cnt shows, in the same cycle and without a clock, the cycle count of the sector on qry_sect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0 read, 1 write, 2 write-without-erase, 3 erase, 4 wear-level) |
| cmd_sect | input | SECT_AW | Command sector |
| busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rej | output | 1 | One-cycle pulse: a command came while busy |
| fl_erase | output | 1 | Erase step strobe |
| fl_prog | output | 1 | Program step strobe |
| fl_verify | output | 1 | Margin verify step strobe |
| fl_read | output | 1 | Read step strobe |
| fl_sect | output | SECT_AW | Sector of the current step |
| fl_done | input | 1 | Back-end finished the current step |
| fl_rdata | input | DATA_W | Back-end read data |
| fl_ecc_err | input | 1 | Back-end read check failure |
| rd_valid | output | 1 | Read result valid, with cmd_done |
| rd_data | output | DATA_W | Read result |
| rd_err | output | 1 | Read error |
| qry_sect | input | SECT_AW | Sector to query |
| qry_cnt | output | CNT_W | Cycle count of the queried sector |

## Verification
The bench's flash model raises fl_done two cycles after it sees a strobe, so each step spans three cycles and a command of k steps shows cmd_done exactly 3k cycles after the first falling edge that follows acceptance. The bench counts those edges and checks the count, then checks at the next falling edge that busy has dropped. Rejection is due one cycle after the refused command and is checked there, and table updates land at the edge that samples the erase or program done, so query checks are made only after cmd_done. All samples are taken at falling edges, half a cycle from the registers that produce them.

// File: rtl/wmode_pkg.sv
package wmode_pkg;

   localparam int NSTEP   = 4;
   localparam int STEP_IW = $clog2(NSTEP);

   // step index order is the issue order
   localparam logic [STEP_IW-1:0] ST_ERASE  = 2'd0;
   localparam logic [STEP_IW-1:0] ST_PROG   = 2'd1;
   localparam logic [STEP_IW-1:0] ST_VERIFY = 2'd2;
   localparam logic [STEP_IW-1:0] ST_READ   = 2'd3;

   localparam logic [2:0] OP_READ  = 3'd0;
   localparam logic [2:0] OP_WRITE = 3'd1;
   localparam logic [2:0] OP_WRNE  = 3'd2;
   localparam logic [2:0] OP_ERASE = 3'd3;
   localparam logic [2:0] OP_WEAR  = 3'd4;

   typedef logic [NSTEP-1:0] step_mask_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_FIN   = 2'd3
   } sq_state_e;

   function automatic logic [STEP_IW-1:0] pick_step(step_mask_t m);
      logic [STEP_IW-1:0] r;
      r = '0;
      for (int i = NSTEP - 1; i >= 0; i--) begin
         if (m[i]) r = STEP_IW'(i);
      end
      return r;
   endfunction

   function automatic step_mask_t step_bit(logic [STEP_IW-1:0] idx);
      return step_mask_t'(1) << idx;
   endfunction

endpackage

// File: rtl/wmode_sector_tab.sv
module wmode_sector_tab #(
   parameter int SECT_AW = 3,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ers_evt,
   input  logic               prg_evt,
   input  logic [SECT_AW-1:0] evt_sect,
   input  logic [SECT_AW-1:0] look_sect,
   output logic               look_erased,
   output logic [CNT_W-1:0]   look_cnt,
   input  logic [SECT_AW-1:0] qry_sect,
   output logic [CNT_W-1:0]   qry_cnt
);

   localparam int             NSECT   = 1 << SECT_AW;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [NSECT-1:0] erased_v;
   logic [CNT_W-1:0] cnt_a [NSECT];

   for (genvar g = 0; g < NSECT; g++) begin : g_sect
      logic             er_q;
      logic [CNT_W-1:0] c_q;
      logic             hit;

      assign hit = (evt_sect == SECT_AW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            er_q <= 1'b0;
            c_q  <= '0;
         end else if (hit && ers_evt) begin
            er_q <= 1'b1;
            if (c_q != CNT_MAX) c_q <= c_q + 1'b1;
         end else if (hit && prg_evt) begin
            er_q <= 1'b0;
         end
      end

      assign erased_v[g] = er_q;
      assign cnt_a[g]    = c_q;
   end

   assign look_erased = erased_v[look_sect];
   assign look_cnt    = cnt_a[look_sect];
   assign qry_cnt     = cnt_a[qry_sect];

endmodule

// File: rtl/wmode_planner.sv
module wmode_planner
   import wmode_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int VERIFY_LIMIT = 16384
) (
   input  logic [2:0]       op,
   input  logic             erased,
   input  logic [CNT_W-1:0] cnt,
   output step_mask_t       plan
);

   localparam logic [CNT_W-1:0] LIM = CNT_W'(VERIFY_LIMIT);

   step_mask_t full_wr;
   logic       over_lim;

   assign over_lim = (cnt > LIM);
   assign full_wr  = step_bit(ST_ERASE) | step_bit(ST_PROG) | step_bit(ST_VERIFY);

   always_comb begin
      plan = '0;
      unique case (op)
         OP_READ:  plan = step_bit(ST_READ);
         OP_WRITE: plan = full_wr;
         OP_ERASE: plan = step_bit(ST_ERASE);
         OP_WRNE: begin
            if (!erased)       plan = full_wr;
            else if (over_lim) plan = step_bit(ST_PROG) | step_bit(ST_VERIFY);
            else               plan = step_bit(ST_PROG);
         end
         default:  plan = '0;
      endcase
   end

endmodule

// File: rtl/wmode_stepper.sv
module wmode_stepper
   import wmode_pkg::*;
#(
   parameter int SECT_AW = 3,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [SECT_AW-1:0] cmd_sect,
   input  step_mask_t         plan,
   input  logic               look_erased,
   input  logic               fl_done,
   input  logic [DATA_W-1:0]  fl_rdata,
   input  logic               fl_ecc_err,
   output logic               busy,
   output logic               cmd_done,
   output logic               cmd_rej,
   output step_mask_t         strobe,
   output logic [SECT_AW-1:0] step_sect,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_err,
   output logic               ers_evt,
   output logic               prg_evt
);

   sq_state_e          state_q;
   logic [2:0]         op_q;
   logic [SECT_AW-1:0] sect_q;
   logic [STEP_IW-1:0] cur_q;
   step_mask_t         pend_q;
   logic               zero_q;
   logic [DATA_W-1:0]  rdat_q;
   logic               rerr_q;
   logic               rej_q;
   logic               step_end;
   logic [STEP_IW-1:0] first_plan;
   logic [STEP_IW-1:0] first_pend;

   assign first_plan = pick_step(plan);
   assign first_pend = pick_step(pend_q);
   assign step_end   = (state_q == SQ_WAIT) && fl_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         op_q    <= '0;
         sect_q  <= '0;
         cur_q   <= '0;
         pend_q  <= '0;
         zero_q  <= 1'b0;
         rdat_q  <= '0;
         rerr_q  <= 1'b0;
         rej_q   <= 1'b0;
      end else begin
         rej_q <= cmd_valid && (state_q != SQ_IDLE);
         unique case (state_q)
            SQ_IDLE: begin
               if (cmd_valid) begin
                  op_q    <= cmd_op;
                  sect_q  <= cmd_sect;
                  zero_q  <= look_erased;
                  cur_q   <= first_plan;
                  pend_q  <= plan & ~step_bit(first_plan);
                  state_q <= (plan == '0) ? SQ_FIN : SQ_ISSUE;
               end
            end
            SQ_ISSUE: state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (fl_done) begin
                  if (cur_q == ST_READ) begin
                     rdat_q <= zero_q ? '0 : fl_rdata;
                     rerr_q <= !zero_q && fl_ecc_err;
                  end
                  if (pend_q != '0) begin
                     cur_q   <= first_pend;
                     pend_q  <= pend_q & ~step_bit(first_pend);
                     state_q <= SQ_ISSUE;
                  end else begin
                     state_q <= SQ_FIN;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NSTEP; g++) begin : g_strobe
      assign strobe[g] = (state_q == SQ_ISSUE) && (cur_q == STEP_IW'(g));
   end

   assign busy      = (state_q != SQ_IDLE);
   assign cmd_done  = (state_q == SQ_FIN);
   assign cmd_rej   = rej_q;
   assign step_sect = sect_q;
   assign rd_valid  = (state_q == SQ_FIN) && (op_q == OP_READ);
   assign rd_data   = rdat_q;
   assign rd_err    = rerr_q;
   assign ers_evt   = step_end && (cur_q == ST_ERASE);
   assign prg_evt   = step_end && (cur_q == ST_PROG);

endmodule

// File: rtl/wmode_seq.sv
module wmode_seq
   import wmode_pkg::*;
#(
   parameter int SECT_AW      = 3,
   parameter int CNT_W        = 16,
   parameter int VERIFY_LIMIT = 16384,
   parameter int DATA_W       = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [SECT_AW-1:0] cmd_sect,
   output logic               busy,
   output logic               cmd_done,
   output logic               cmd_rej,
   output logic               fl_erase,
   output logic               fl_prog,
   output logic               fl_verify,
   output logic               fl_read,
   output logic [SECT_AW-1:0] fl_sect,
   input  logic               fl_done,
   input  logic [DATA_W-1:0]  fl_rdata,
   input  logic               fl_ecc_err,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_err,
   input  logic [SECT_AW-1:0] qry_sect,
   output logic [CNT_W-1:0]   qry_cnt
);

   localparam longint CNT_TOP = (longint'(1) << CNT_W) - 1;

   if (SECT_AW < 1 || SECT_AW > 8) begin : g_bad_sect_aw
      $error("wmode_seq: SECT_AW must be 1..8");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
      $error("wmode_seq: CNT_W must be 2..31");
   end
   if (VERIFY_LIMIT < 0 || longint'(VERIFY_LIMIT) >= CNT_TOP) begin : g_bad_limit
      $error("wmode_seq: VERIFY_LIMIT must be below the counter maximum");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("wmode_seq: DATA_W must be positive");
   end

   logic               ers_evt;
   logic               prg_evt;
   logic               look_erased;
   logic [CNT_W-1:0]   look_cnt;
   step_mask_t         plan;
   step_mask_t         strobe;

   wmode_sector_tab #(
      .SECT_AW (SECT_AW),
      .CNT_W   (CNT_W)
   ) i_tab (
      .clk         (clk),
      .rst_n       (rst_n),
      .ers_evt     (ers_evt),
      .prg_evt     (prg_evt),
      .evt_sect    (fl_sect),
      .look_sect   (cmd_sect),
      .look_erased (look_erased),
      .look_cnt    (look_cnt),
      .qry_sect    (qry_sect),
      .qry_cnt     (qry_cnt)
   );

   wmode_planner #(
      .CNT_W        (CNT_W),
      .VERIFY_LIMIT (VERIFY_LIMIT)
   ) i_plan (
      .op     (cmd_op),
      .erased (look_erased),
      .cnt    (look_cnt),
      .plan   (plan)
   );

   wmode_stepper #(
      .SECT_AW (SECT_AW),
      .DATA_W  (DATA_W)
   ) i_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_sect    (cmd_sect),
      .plan        (plan),
      .look_erased (look_erased),
      .fl_done     (fl_done),
      .fl_rdata    (fl_rdata),
      .fl_ecc_err  (fl_ecc_err),
      .busy        (busy),
      .cmd_done    (cmd_done),
      .cmd_rej     (cmd_rej),
      .strobe      (strobe),
      .step_sect   (fl_sect),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .rd_err      (rd_err),
      .ers_evt     (ers_evt),
      .prg_evt     (prg_evt)
   );

   assign fl_erase  = strobe[ST_ERASE];
   assign fl_prog   = strobe[ST_PROG];
   assign fl_verify = strobe[ST_VERIFY];
   assign fl_read   = strobe[ST_READ];

endmodule

// File: rtl/wmode_seq_chk.sv
module wmode_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic cmd_done,
   input logic cmd_rej,
   input logic fl_erase,
   input logic fl_prog,
   input logic fl_verify,
   input logic fl_read,
   input logic rd_valid
);

   logic [3:0] stb;
   assign stb = {fl_read, fl_verify, fl_prog, fl_erase};

   // R1: steps never overlap
   p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));

   // R10: refusal pulse follows a command seen while busy
   p_reject_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |=> cmd_rej);

   // R10: no refusal after an idle cycle
   p_no_reject_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !cmd_rej);

   // R11: accepted command makes the block busy
   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);

   // R11: strobes only while busy
   p_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stb != 4'b0) |-> busy);

   // R11: completion releases busy
   p_done_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !busy);

   // R11: strobes are single-cycle
   p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stb != 4'b0) |=> (stb == 4'b0));

   // R7: read result only with completion
   p_rdvalid_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> cmd_done);

endmodule

bind wmode_seq wmode_seq_chk i_wmode_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .cmd_done  (cmd_done),
   .cmd_rej   (cmd_rej),
   .fl_erase  (fl_erase),
   .fl_prog   (fl_prog),
   .fl_verify (fl_verify),
   .fl_read   (fl_read),
   .rd_valid  (rd_valid)
);

// File: tb/test_wmode_seq.sv
`timescale 1ns/1ps
module test_wmode_seq;

   localparam int SECT_AW = 3;
   localparam int CNT_W   = 4;
   localparam int LIMIT   = 3;
   localparam int DATA_W  = 32;
   localparam int LAT     = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cmd_valid = 1'b0;
   logic [2:0]         cmd_op = '0;
   logic [SECT_AW-1:0] cmd_sect = '0;
   logic               busy, cmd_done, cmd_rej;
   logic               fl_erase, fl_prog, fl_verify, fl_read;
   logic [SECT_AW-1:0] fl_sect;
   logic               fl_done = 1'b0;
   logic [DATA_W-1:0]  fl_rdata = '0;
   logic               fl_ecc_err = 1'b0;
   logic               rd_valid, rd_err;
   logic [DATA_W-1:0]  rd_data;
   logic [SECT_AW-1:0] qry_sect = '0;
   logic [CNT_W-1:0]   qry_cnt;

   int          nchk = 0;
   int          nfail = 0;
   logic [15:0] slog;
   logic [SECT_AW-1:0] exp_sect;
   logic        sect_bad;
   logic        last_rv, last_re;
   logic [DATA_W-1:0] last_rd;

   always #2 clk = ~clk;

   wmode_seq #(
      .SECT_AW (SECT_AW), .CNT_W (CNT_W), .VERIFY_LIMIT (LIMIT), .DATA_W (DATA_W)
   ) i_wmode_seq (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_sect (cmd_sect), .busy (busy), .cmd_done (cmd_done), .cmd_rej (cmd_rej),
      .fl_erase (fl_erase), .fl_prog (fl_prog), .fl_verify (fl_verify),
      .fl_read (fl_read), .fl_sect (fl_sect), .fl_done (fl_done),
      .fl_rdata (fl_rdata), .fl_ecc_err (fl_ecc_err), .rd_valid (rd_valid),
      .rd_data (rd_data), .rd_err (rd_err), .qry_sect (qry_sect), .qry_cnt (qry_cnt)
   );

   // flash model: log step codes (1 erase, 2 program, 3 verify, 4 read)
   initial begin
      slog = '0; sect_bad = 1'b0; exp_sect = '0;
      @(negedge clk);
      forever begin
         if (fl_erase || fl_prog || fl_verify || fl_read) begin
            slog = {slog[11:0], fl_erase ? 4'd1 : fl_prog ? 4'd2 : fl_verify ? 4'd3 : 4'd4};
            if (fl_sect !== exp_sect) sect_bad = 1'b1;
            repeat (LAT) @(negedge clk);
            fl_done = 1'b1;
            @(negedge clk);
            fl_done = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qcheck(string req, int sect, int exp);
      qry_sect = SECT_AW'(sect);
      #1;
      check(req, 64'(qry_cnt), 64'(exp));
   endtask

   task automatic run_cmd(string req, logic [2:0] op, int sect, logic [15:0] exp_log, int nsteps);
      int   c;
      logic bz;
      @(negedge clk);
      exp_sect = SECT_AW'(sect); slog = '0; sect_bad = 1'b0;
      cmd_valid = 1'b1; cmd_op = op; cmd_sect = SECT_AW'(sect);
      @(negedge clk);
      cmd_valid = 1'b0;
      c = 0; bz = 1'b1;
      while (!cmd_done && c < 60) begin
         if (!busy) bz = 1'b0;
         @(negedge clk);
         c++;
      end
      last_rv = rd_valid; last_rd = rd_data; last_re = rd_err;
      check({req, " step order"}, 64'(slog), 64'(exp_log));
      check({req, " sector"}, 64'(sect_bad), 64'd0);
      check("R11 latency", 64'(c), 64'(3 * nsteps));
      check("R11 busy held", 64'(bz && busy), 64'd1);
      @(negedge clk);
      check("R11 busy released", 64'(busy), 64'd0);
   endtask

   task automatic t_reset;
      check("R12 busy", 64'(busy), 64'd0);
      check("R12 done", 64'(cmd_done), 64'd0);
      check("R12 rej", 64'(cmd_rej), 64'd0);
      check("R12 strobes", 64'({fl_erase, fl_prog, fl_verify, fl_read}), 64'd0);
      for (int s = 0; s < 8; s++) qcheck("R12 count", s, 0);
      fl_rdata = 32'hA5A5_5A5A; fl_ecc_err = 1'b1;
      run_cmd("R12 read fresh", 3'd0, 0, 16'h0004, 1);
      check("R8 rd_valid", 64'(last_rv), 64'd1);
      check("R8 data", 64'(last_rd), 64'hA5A5_5A5A);
      check("R8 err", 64'(last_re), 64'd1);
   endtask

   task automatic t_normal;
      run_cmd("R1 write fresh", 3'd1, 0, 16'h0123, 3);
      qcheck("R2 count after write", 0, 1);
      run_cmd("R2 erase", 3'd3, 3, 16'h0001, 1);
      run_cmd("R1 write erased", 3'd1, 3, 16'h0123, 3);
      qcheck("R2 count sect3", 3, 2);
   endtask

   task automatic t_erased_read;
      run_cmd("R2 erase sect1", 3'd3, 1, 16'h0001, 1);
      qcheck("R2 count sect1", 1, 1);
      fl_rdata = 32'hDEAD_BEEF; fl_ecc_err = 1'b1;
      run_cmd("R7 read erased", 3'd0, 1, 16'h0004, 1);
      check("R7 rd_valid", 64'(last_rv), 64'd1);
      check("R7 zero data", 64'(last_rd), 64'd0);
      check("R7 no error", 64'(last_re), 64'd0);
   endtask

   task automatic t_fast_write;
      run_cmd("R3 fast write", 3'd2, 1, 16'h0002, 1);
      qcheck("R3 count unchanged", 1, 1);
      run_cmd("R6 read after program", 3'd0, 1, 16'h0004, 1);
      check("R6 data passes", 64'(last_rd), 64'hDEAD_BEEF);
      check("R6 error passes", 64'(last_re), 64'd1);
      run_cmd("R5 fallback write", 3'd2, 1, 16'h0123, 3);
      qcheck("R5 count", 1, 2);
   endtask

   task automatic t_threshold;
      for (int i = 0; i < 3; i++) run_cmd("R2 erase sect2", 3'd3, 2, 16'h0001, 1);
      qcheck("R3 count at limit", 2, 3);
      run_cmd("R3 at limit no verify", 3'd2, 2, 16'h0002, 1);
      run_cmd("R2 erase sect2", 3'd3, 2, 16'h0001, 1);
      qcheck("R4 count over limit", 2, 4);
      run_cmd("R4 over limit verify", 3'd2, 2, 16'h0023, 2);
   endtask

   task automatic t_wear;
      run_cmd("R2 erase sect7", 3'd3, 7, 16'h0001, 1);
      run_cmd("R9 wear-level", 3'd4, 7, 16'h0000, 0);
      run_cmd("R9 unused code", 3'd7, 7, 16'h0000, 0);
      qcheck("R9 count kept", 7, 1);
      run_cmd("R9 flag kept", 3'd2, 7, 16'h0002, 1);
   endtask

   task automatic t_reject;
      int c;
      @(negedge clk);
      exp_sect = 3'd4; slog = '0; sect_bad = 1'b0;
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_sect = 3'd4;
      @(negedge clk);
      cmd_op = 3'd3; cmd_sect = 3'd6;
      @(negedge clk);
      check("R10 rej pulse", 64'(cmd_rej), 64'd1);
      cmd_valid = 1'b0;
      @(negedge clk);
      check("R10 rej single", 64'(cmd_rej), 64'd0);
      c = 0;
      while (!cmd_done && c < 60) begin @(negedge clk); c++; end
      check("R10 steps unaffected", 64'(slog), 64'h0123);
      check("R10 sector", 64'(sect_bad), 64'd0);
      @(negedge clk);
      qcheck("R10 rejected no effect", 6, 0);
      qcheck("R10 accepted count", 4, 1);
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 17; i++) run_cmd("R2 erase sect5", 3'd3, 5, 16'h0001, 1);
      qcheck("R2 saturation", 5, 15);
   endtask

   task automatic t_query;
      qcheck("R13 query s0", 0, 1);
      qcheck("R13 query s1", 1, 2);
      qcheck("R13 query s2", 2, 4);
      qcheck("R13 query s3", 3, 2);
      qcheck("R13 query s6", 6, 0);
   endtask

   initial begin
      #100000;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_normal;
      t_erased_read;
      t_fast_write;
      t_threshold;
      t_wear;
      t_reject;
      t_saturate;
      t_query;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule